// File: doc/BRIEF.md
# Translation Fault Checker and Logger

This block sits after the translation lookaside lookup of a memory pipeline. It takes one translation request (virtual address, access size, access kind, privilege state, context selection) together with the lookup's hit/miss result and the attribute bits of the matching page. It returns either a physical address with a cacheability attribute or a fault kind. The fault checks are evaluated in a fixed priority, and the first one that fails decides the outcome.

On a fault the block records the event in three registers that software reads through other paths: a fault status word, a fault address and a tag-access word. The fault status word carries an overwrite mark when a new fault arrives before the previous one has been cleared. A small three-state controller accepts a request in `S_IDLE` (transition T_ACCEPT), evaluates it in `S_EVAL` (transition T_DECIDE, which loads all result and log registers), and presents a one-cycle response in `S_RESP` (transition T_RETIRE back to `S_IDLE`). Lookup itself and address-space decoding other than primary, secondary and nucleus are done elsewhere.

Top module: `xlat_fault_chk`

## Requirements
- R1: After reset, fault_status, fault_addr and tag_access are zero, ready is 1 and rsp_valid is 0.
- R2: A request is taken when req_valid and ready are both 1 on a clock edge. ready is 0 for the next two cycles. rsp_valid is 1 for exactly one cycle, starting after the second edge following acceptance.
- R3: Checks are applied in this order, and the first failure sets rsp_fault: misalignment (va AND (2^size_log2 - 1) nonzero) gives 1; virtual-address hole gives 2; miss gives 3 or 4; user access (req_priv=0) to a privileged page gives 2; write to a non-writable page gives 5; a no-fault page touched by a normal access (req_nofault_acc=0) gives 2; a side-effect page touched by a no-fault access gives 2. Success gives 0.
- R4: With req_addr_mask=1 the upper 32 address bits are cleared before all later checks and before logging into tag_access, and the hole check is skipped. Otherwise an address in [HOLE_LO, HOLE_HI] faults.
- R5: A miss gives rsp_fault 3 (real-translation miss) when req_xlat_on=0, and 4 (translation miss) otherwise.
- R6: An aligned request with req_implicit=1 and req_hpriv=1 bypasses all later checks. It returns rsp_fault 0, rsp_pa equal to the low PA_W address bits, and rsp_uncached 0, whatever the hit inputs are.
- R7: On success rsp_pa is {pg_ppn, va[12:0]}, and rsp_uncached is 1 exactly when pg_side_effect is 1 or rsp_pa bit UC_BIT (39) is 1.
- R8: On rsp_fault 1, 2 or 5, fault_status is loaded as follows. Bit 0 is 1. Bit 2 is req_write. Bits 5:4 are the context type (0 primary, 1 secondary, 2 nucleus). Bit 6 is pg_side_effect for page-attribute faults, and 0 for misalignment or hole faults. Bits 15:7 are the fault type: 1 privilege, 2 side-effect, 4 no-fault load, 8 address range, 16 other (misalignment or write protection). Bits 23:16 are req_asi. All other bits are 0. Misses leave fault_status unchanged.
- R9: Bit 1 of a newly written fault_status equals bit 0 of its previous value (overwrite mark).
- R10: On misses and page-attribute faults, tag_access is loaded with {va[63:13], context[12:0]}. Misalignment and hole faults leave it unchanged.
- R11: An implicit access uses the nucleus type with context 0 when req_trap_lvl > 0, and the primary type with pri_ctx otherwise. An explicit access uses req_ctx_type: 0 primary/pri_ctx, 1 secondary/sec_ctx, 2 nucleus/0, 3 treated as primary. When req_xlat_on=0 the logged context value is 0.
- R12: A fault that writes fault_status loads fault_addr with the unmasked request address when req_data_side=1. Instruction-side faults leave fault_addr unchanged.
- R13: stat_clear=1 on an edge clears fault_status, unless a fault writes it on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| ready | output | 1 | Controller idle, request can be taken |
| req_va | input | VA_W | Virtual address |
| req_size_log2 | input | 2 | Access size as log2 of bytes |
| req_write | input | 1 | Store access |
| req_priv | input | 1 | Privileged mode |
| req_hpriv | input | 1 | Hyperprivileged mode |
| req_addr_mask | input | 1 | 32-bit address masking enabled |
| req_trap_lvl | input | 3 | Current trap level |
| req_xlat_on | input | 1 | Translation enabled (0 = real mode) |
| req_implicit | input | 1 | Access uses the default address space |
| req_nofault_acc | input | 1 | No-fault (speculative) access |
| req_ctx_type | input | 2 | Context selection for explicit accesses |
| req_asi | input | 8 | Address space identifier, logged only |
| req_data_side | input | 1 | Data-side request (0 = instruction fetch) |
| pri_ctx | input | CTX_W | Primary context value |
| sec_ctx | input | CTX_W | Secondary context value |
| hit | input | 1 | Lookup found a page |
| pg_priv | input | 1 | Page is privileged |
| pg_writable | input | 1 | Page is writable |
| pg_nofault | input | 1 | Page permits only no-fault accesses |
| pg_side_effect | input | 1 | Page has side effects |
| pg_ppn | input | PA_W-13 | Physical page number |
| stat_clear | input | 1 | Clear the fault status word |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 3 | Fault kind, 0 = none |
| rsp_pa | output | PA_W | Physical address |
| rsp_uncached | output | 1 | Uncacheable, strictly ordered |
| fault_status | output | 64 | Fault status word |
| fault_addr | output | VA_W | Fault address |
| tag_access | output | VA_W | Tag-access word |

## Verification
The bound checker watches every cycle for four things. Each response lasts one cycle and never overlaps with ready. A faulting response is never marked uncacheable. Every logged fault sets status bit 0 and carries the previous bit 0 into the overwrite mark. Misses never change the status word. The check priority, the address hole and masking, the hyperprivileged bypass, context selection, the exact status encoding and the conditions for updating the address and tag registers need concrete stimuli, so the bench's scenarios drive each case and compare against a reference model of the requirements.

// File: rtl/xfc_pkg.sv
package xfc_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_EVAL = 2'd1,
        S_RESP = 2'd2
    } xfc_state_e;

    typedef enum logic [2:0] {
        XF_NONE      = 3'd0,
        XF_MISALIGN  = 3'd1,
        XF_ACCESS    = 3'd2,
        XF_REAL_MISS = 3'd3,
        XF_MMU_MISS  = 3'd4,
        XF_PROTECT   = 3'd5
    } xf_kind_e;

    localparam int FT_W = 9;
    localparam logic [FT_W-1:0] FT_PRIV    = 9'd1;
    localparam logic [FT_W-1:0] FT_SIDEEFF = 9'd2;
    localparam logic [FT_W-1:0] FT_NFO     = 9'd4;
    localparam logic [FT_W-1:0] FT_RANGE   = 9'd8;
    localparam logic [FT_W-1:0] FT_OTHER   = 9'd16;

    localparam logic [1:0] CT_PRIMARY   = 2'd0;
    localparam logic [1:0] CT_SECONDARY = 2'd1;
    localparam logic [1:0] CT_NUCLEUS   = 2'd2;

    typedef struct packed {
        logic [1:0] size_log2;
        logic       write;
        logic       priv;
        logic       hpriv;
        logic       amask;
        logic [2:0] trap_lvl;
        logic       xlat_on;
        logic       implicit;
        logic       nf_acc;
        logic [1:0] ctx_type;
        logic [7:0] asi;
        logic       data_side;
        logic       hit;
        logic       pg_priv;
        logic       pg_wr;
        logic       pg_nf;
        logic       pg_se;
    } xfc_req_t;

endpackage

// File: rtl/xfc_ctx_sel.sv
module xfc_ctx_sel #(
    parameter int CTX_W = 13
) (
    input  logic             implicit,
    input  logic [2:0]       trap_lvl,
    input  logic [1:0]       ctx_type_in,
    input  logic             xlat_on,
    input  logic [CTX_W-1:0] pri_ctx,
    input  logic [CTX_W-1:0] sec_ctx,
    output logic [1:0]       ctx_type,
    output logic [CTX_W-1:0] ctx_val
);
    import xfc_pkg::*;

    logic [CTX_W-1:0] sel_val;

    always_comb begin
        if (implicit) begin
            if (trap_lvl != 3'd0) begin
                ctx_type = CT_NUCLEUS;
                sel_val  = '0;
            end else begin
                ctx_type = CT_PRIMARY;
                sel_val  = pri_ctx;
            end
        end else begin
            unique case (ctx_type_in)
                CT_SECONDARY: begin ctx_type = CT_SECONDARY; sel_val = sec_ctx; end
                CT_NUCLEUS:   begin ctx_type = CT_NUCLEUS;   sel_val = '0;      end
                default:      begin ctx_type = CT_PRIMARY;   sel_val = pri_ctx; end
            endcase
        end
        ctx_val = xlat_on ? sel_val : '0;
    end

endmodule

// File: rtl/xfc_checks.sv
module xfc_checks #(
    parameter int              VA_W     = 64,
    parameter int              PA_W     = 40,
    parameter int              PG_SHIFT = 13,
    parameter int              UC_BIT   = 39,
    parameter logic [VA_W-1:0] HOLE_LO  = 64'h0000_8000_0000_0000,
    parameter logic [VA_W-1:0] HOLE_HI  = 64'hFFFF_7FFF_FFFF_FFFF
) (
    input  logic [VA_W-1:0]          va,
    input  xfc_pkg::xfc_req_t        rq,
    input  logic [PA_W-PG_SHIFT-1:0] ppn,
    output xfc_pkg::xf_kind_e        kind,
    output logic [xfc_pkg::FT_W-1:0] ftype,
    output logic                     se_flag,
    output logic                     wr_fsr,
    output logic                     wr_tag,
    output logic [VA_W-1:0]          va_eff,
    output logic [PA_W-1:0]          pa,
    output logic                     uc
);
    import xfc_pkg::*;

    localparam int HALF_W = 32;

    logic [VA_W-1:0] size_mask;
    logic            misal, in_hole, bypass;

    always_comb begin
        va_eff    = rq.amask ? {{(VA_W-HALF_W){1'b0}}, va[HALF_W-1:0]} : va;
        size_mask = (VA_W'(1) << rq.size_log2) - VA_W'(1);
        misal     = |(va & size_mask);
        bypass    = rq.implicit && rq.hpriv;
        in_hole   = !rq.amask && (va_eff >= HOLE_LO) && (va_eff <= HOLE_HI);

        kind    = XF_NONE;
        ftype   = '0;
        se_flag = 1'b0;
        wr_fsr  = 1'b0;
        wr_tag  = 1'b0;
        pa      = {ppn, va_eff[PG_SHIFT-1:0]};
        uc      = 1'b0;

        if (misal) begin
            kind = XF_MISALIGN; ftype = FT_OTHER; wr_fsr = 1'b1;
        end else if (bypass) begin
            pa = va_eff[PA_W-1:0];
        end else if (in_hole) begin
            kind = XF_ACCESS; ftype = FT_RANGE; wr_fsr = 1'b1;
        end else if (!rq.hit) begin
            kind   = rq.xlat_on ? XF_MMU_MISS : XF_REAL_MISS;
            wr_tag = 1'b1;
        end else if (!rq.priv && rq.pg_priv) begin
            kind = XF_ACCESS; ftype = FT_PRIV;
            se_flag = rq.pg_se; wr_fsr = 1'b1; wr_tag = 1'b1;
        end else if (rq.write && !rq.pg_wr) begin
            kind = XF_PROTECT; ftype = FT_OTHER;
            se_flag = rq.pg_se; wr_fsr = 1'b1; wr_tag = 1'b1;
        end else if (rq.pg_nf && !rq.nf_acc) begin
            kind = XF_ACCESS; ftype = FT_NFO;
            se_flag = rq.pg_se; wr_fsr = 1'b1; wr_tag = 1'b1;
        end else if (rq.pg_se && rq.nf_acc) begin
            kind = XF_ACCESS; ftype = FT_SIDEEFF;
            se_flag = rq.pg_se; wr_fsr = 1'b1; wr_tag = 1'b1;
        end else begin
            uc = rq.pg_se || pa[UC_BIT];
        end
    end

endmodule

// File: rtl/xfc_fsr_fmt.sv
module xfc_fsr_fmt (
    input  logic                     prev_bit0,
    input  logic                     write,
    input  logic [1:0]               ctx_type,
    input  logic                     se_flag,
    input  logic [xfc_pkg::FT_W-1:0] ftype,
    input  logic [7:0]               asi,
    output logic [63:0]              word
);
    always_comb begin
        word        = '0;
        word[0]     = 1'b1;
        word[1]     = prev_bit0;
        word[2]     = write;
        word[5:4]   = ctx_type;
        word[6]     = se_flag;
        word[15:7]  = ftype;
        word[23:16] = asi;
    end
endmodule

// File: rtl/xlat_fault_chk.sv
module xlat_fault_chk #(
    parameter int              VA_W     = 64,
    parameter int              PA_W     = 40,
    parameter int              UC_BIT   = 39,
    parameter logic [VA_W-1:0] HOLE_LO  = 64'h0000_8000_0000_0000,
    parameter logic [VA_W-1:0] HOLE_HI  = 64'hFFFF_7FFF_FFFF_FFFF,
    localparam int             PG_SHIFT = 13,
    localparam int             CTX_W    = PG_SHIFT,
    localparam int             PPN_W    = PA_W - PG_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             ready,
    input  logic [VA_W-1:0]  req_va,
    input  logic [1:0]       req_size_log2,
    input  logic             req_write,
    input  logic             req_priv,
    input  logic             req_hpriv,
    input  logic             req_addr_mask,
    input  logic [2:0]       req_trap_lvl,
    input  logic             req_xlat_on,
    input  logic             req_implicit,
    input  logic             req_nofault_acc,
    input  logic [1:0]       req_ctx_type,
    input  logic [7:0]       req_asi,
    input  logic             req_data_side,
    input  logic [CTX_W-1:0] pri_ctx,
    input  logic [CTX_W-1:0] sec_ctx,
    input  logic             hit,
    input  logic             pg_priv,
    input  logic             pg_writable,
    input  logic             pg_nofault,
    input  logic             pg_side_effect,
    input  logic [PPN_W-1:0] pg_ppn,
    input  logic             stat_clear,
    output logic             rsp_valid,
    output logic [2:0]       rsp_fault,
    output logic [PA_W-1:0]  rsp_pa,
    output logic             rsp_uncached,
    output logic [63:0]      fault_status,
    output logic [VA_W-1:0]  fault_addr,
    output logic [VA_W-1:0]  tag_access
);
    import xfc_pkg::*;

    xfc_state_e        state, state_nx;
    xfc_req_t          rq_q;
    logic [VA_W-1:0]   va_q;
    logic [PPN_W-1:0]  ppn_q;

    xf_kind_e          kind;
    logic [FT_W-1:0]   ftype;
    logic              se_flag, wr_fsr, wr_tag, uc;
    logic [VA_W-1:0]   va_eff;
    logic [PA_W-1:0]   pa;
    logic [1:0]        ctx_type;
    logic [CTX_W-1:0]  ctx_val;
    logic [63:0]       fsr_word;

    xfc_ctx_sel #(.CTX_W(CTX_W)) u_ctx (
        .implicit    (rq_q.implicit),
        .trap_lvl    (rq_q.trap_lvl),
        .ctx_type_in (rq_q.ctx_type),
        .xlat_on     (rq_q.xlat_on),
        .pri_ctx     (pri_ctx),
        .sec_ctx     (sec_ctx),
        .ctx_type    (ctx_type),
        .ctx_val     (ctx_val)
    );

    xfc_checks #(
        .VA_W(VA_W), .PA_W(PA_W), .PG_SHIFT(PG_SHIFT), .UC_BIT(UC_BIT),
        .HOLE_LO(HOLE_LO), .HOLE_HI(HOLE_HI)
    ) u_chk (
        .va      (va_q),
        .rq      (rq_q),
        .ppn     (ppn_q),
        .kind    (kind),
        .ftype   (ftype),
        .se_flag (se_flag),
        .wr_fsr  (wr_fsr),
        .wr_tag  (wr_tag),
        .va_eff  (va_eff),
        .pa      (pa),
        .uc      (uc)
    );

    xfc_fsr_fmt u_fmt (
        .prev_bit0 (fault_status[0]),
        .write     (rq_q.write),
        .ctx_type  (ctx_type),
        .se_flag   (se_flag),
        .ftype     (ftype),
        .asi       (rq_q.asi),
        .word      (fsr_word)
    );

    // Next state: T_ACCEPT, T_DECIDE, T_RETIRE
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (req_valid) state_nx = S_EVAL;
            S_EVAL:  state_nx = S_RESP;
            S_RESP:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    assign ready = (state == S_IDLE);

    // Request capture and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_q         <= '0;
            va_q         <= '0;
            ppn_q        <= '0;
            rsp_valid    <= 1'b0;
            rsp_fault    <= '0;
            rsp_pa       <= '0;
            rsp_uncached <= 1'b0;
            fault_status <= '0;
            fault_addr   <= '0;
            tag_access   <= '0;
        end else begin
            rsp_valid <= (state == S_EVAL);
            if (state == S_IDLE && req_valid) begin
                va_q  <= req_va;
                ppn_q <= pg_ppn;
                rq_q  <= '{size_log2: req_size_log2, write: req_write,
                           priv: req_priv, hpriv: req_hpriv,
                           amask: req_addr_mask, trap_lvl: req_trap_lvl,
                           xlat_on: req_xlat_on, implicit: req_implicit,
                           nf_acc: req_nofault_acc, ctx_type: req_ctx_type,
                           asi: req_asi, data_side: req_data_side, hit: hit,
                           pg_priv: pg_priv, pg_wr: pg_writable,
                           pg_nf: pg_nofault, pg_se: pg_side_effect};
            end
            if (state == S_EVAL) begin
                rsp_fault    <= kind;
                rsp_pa       <= (kind == XF_NONE) ? pa : '0;
                rsp_uncached <= uc;
                if (wr_tag)
                    tag_access <= {va_eff[VA_W-1:PG_SHIFT], ctx_val};
                if (wr_fsr && rq_q.data_side)
                    fault_addr <= va_q;
            end
            if (state == S_EVAL && wr_fsr)
                fault_status <= fsr_word;
            else if (stat_clear)
                fault_status <= '0;
        end
    end

endmodule

// File: rtl/xlat_fault_chk_sva.sv
module xlat_fault_chk_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        ready,
    input logic        rsp_valid,
    input logic [2:0]  rsp_fault,
    input logic        rsp_uncached,
    input logic [63:0] fault_status,
    input logic        stat_clear
);
    logic logged, missed;
    assign logged = rsp_valid && (rsp_fault == 3'd1 || rsp_fault == 3'd2 || rsp_fault == 3'd5);
    assign missed = rsp_valid && (rsp_fault == 3'd3 || rsp_fault == 3'd4);

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R2
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !ready); // R2
    AST_NO_UC_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 3'd0) |-> !rsp_uncached); // R7
    AST_FSR_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        logged |-> fault_status[0]); // R8
    AST_FSR_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        logged |-> (fault_status[1] == $past(fault_status[0]))); // R9
    AST_MISS_KEEPS_FSR: assert property (@(posedge clk) disable iff (!rst_n)
        (missed && !$past(stat_clear)) |-> $stable(fault_status)); // R8
endmodule

bind xlat_fault_chk xlat_fault_chk_sva u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .ready        (ready),
    .rsp_valid    (rsp_valid),
    .rsp_fault    (rsp_fault),
    .rsp_uncached (rsp_uncached),
    .fault_status (fault_status),
    .stat_clear   (stat_clear)
);

// File: tb/xlat_fault_chk_test.sv
`timescale 1ns/100ps
module xlat_fault_chk_test;

    localparam logic [12:0] PRI = 13'h0A5;
    localparam logic [12:0] SEC = 13'h1C3;
    localparam logic [63:0] H_LO = 64'h0000_8000_0000_0000;
    localparam logic [63:0] H_HI = 64'hFFFF_7FFF_FFFF_FFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        req_valid = 1'b0, ready;
    logic [63:0] req_va = '0;
    logic [1:0]  req_size_log2 = '0, req_ctx_type = '0;
    logic        req_write = 0, req_priv = 0, req_hpriv = 0, req_addr_mask = 0;
    logic [2:0]  req_trap_lvl = '0;
    logic        req_xlat_on = 0, req_implicit = 0, req_nofault_acc = 0, req_data_side = 0;
    logic [7:0]  req_asi = '0;
    logic        hit = 0, pg_priv = 0, pg_writable = 0, pg_nofault = 0, pg_side_effect = 0;
    logic [26:0] pg_ppn = '0;
    logic        stat_clear = 1'b0;
    logic        rsp_valid, rsp_uncached;
    logic [2:0]  rsp_fault;
    logic [39:0] rsp_pa;
    logic [63:0] fault_status, fault_addr, tag_access;

    xlat_fault_chk uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ready(ready),
        .req_va(req_va), .req_size_log2(req_size_log2), .req_write(req_write),
        .req_priv(req_priv), .req_hpriv(req_hpriv), .req_addr_mask(req_addr_mask),
        .req_trap_lvl(req_trap_lvl), .req_xlat_on(req_xlat_on),
        .req_implicit(req_implicit), .req_nofault_acc(req_nofault_acc),
        .req_ctx_type(req_ctx_type), .req_asi(req_asi), .req_data_side(req_data_side),
        .pri_ctx(PRI), .sec_ctx(SEC), .hit(hit), .pg_priv(pg_priv),
        .pg_writable(pg_writable), .pg_nofault(pg_nofault),
        .pg_side_effect(pg_side_effect), .pg_ppn(pg_ppn), .stat_clear(stat_clear),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
        .rsp_uncached(rsp_uncached), .fault_status(fault_status),
        .fault_addr(fault_addr), .tag_access(tag_access)
    );

    typedef struct {
        logic [63:0] va; logic [1:0] szl; logic wr, priv, hpriv, amask;
        logic [2:0] tl; logic xen, impl, nfa; logic [1:0] ct; logic [7:0] asi;
        logic data, hit, ppriv, pwr, pnf, pse; logic [26:0] ppn;
    } stim_t;

    typedef struct {
        string name; logic [2:0] kind; logic [39:0] pa; logic uc;
        logic [63:0] fsr, far, tag;
    } exp_t;

    exp_t q[$];
    int total = 0, fails = 0;
    bit done = 0;
    logic [63:0] m_fsr = '0, m_far = '0, m_tag = '0;

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] ex);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, ex);
        end
    endtask

    function automatic stim_t base();
        stim_t s;
        s.va = 64'h0000_0000_1000_2008; s.szl = 2'd3; s.wr = 0; s.priv = 1; s.hpriv = 0;
        s.amask = 0; s.tl = 0; s.xen = 1; s.impl = 1; s.nfa = 0; s.ct = 0; s.asi = 8'h80;
        s.data = 1; s.hit = 1; s.ppriv = 0; s.pwr = 1; s.pnf = 0; s.pse = 0; s.ppn = 27'h0004321;
        return s;
    endfunction

    // Reference model built from the requirements
    function automatic exp_t model(input stim_t s, input string name);
        exp_t e;
        logic [63:0] ve; logic [1:0] ctt; logic [12:0] cv;
        logic [8:0] ft; logic se, wf, wt, mis;
        e.name = name; e.kind = 0; e.uc = 0; e.pa = '0;
        ft = 0; se = 0; wf = 0; wt = 0;
        ve = s.amask ? {32'b0, s.va[31:0]} : s.va;                      // R4
        if (s.impl) begin ctt = (s.tl != 0) ? 2'd2 : 2'd0; cv = (s.tl != 0) ? 13'd0 : PRI; end // R11
        else if (s.ct == 2'd1) begin ctt = 2'd1; cv = SEC; end
        else if (s.ct == 2'd2) begin ctt = 2'd2; cv = 13'd0; end
        else begin ctt = 2'd0; cv = PRI; end
        if (!s.xen) cv = 13'd0;
        mis = (s.va & ((64'd1 << s.szl) - 64'd1)) != 0;
        if (mis) begin e.kind = 1; ft = 16; wf = 1; end                 // R3
        else if (s.impl && s.hpriv) e.pa = ve[39:0];                    // R6
        else if (!s.amask && ve >= H_LO && ve <= H_HI) begin e.kind = 2; ft = 8; wf = 1; end
        else if (!s.hit) begin e.kind = s.xen ? 3'd4 : 3'd3; wt = 1; end // R5
        else if (!s.priv && s.ppriv) begin e.kind = 2; ft = 1; se = s.pse; wf = 1; wt = 1; end
        else if (s.wr && !s.pwr) begin e.kind = 5; ft = 16; se = s.pse; wf = 1; wt = 1; end
        else if (s.pnf && !s.nfa) begin e.kind = 2; ft = 4; se = s.pse; wf = 1; wt = 1; end
        else if (s.pse && s.nfa) begin e.kind = 2; ft = 2; se = s.pse; wf = 1; wt = 1; end
        else begin e.pa = {s.ppn, ve[12:0]}; e.uc = s.pse | e.pa[39]; end // R7
        if (wf) begin
            m_fsr = {40'b0, s.asi, ft, se, ctt, 1'b0, s.wr, m_fsr[0], 1'b1}; // R8 R9
            if (s.data) m_far = s.va;                                    // R12
        end
        if (wt) m_tag = {ve[63:13], cv};                                 // R10
        e.fsr = m_fsr; e.far = m_far; e.tag = m_tag;
        return e;
    endfunction

    task automatic issue(input stim_t s, input string name);
        q.push_back(model(s, name));
        @(negedge clk);
        req_valid = 1; req_va = s.va; req_size_log2 = s.szl; req_write = s.wr;
        req_priv = s.priv; req_hpriv = s.hpriv; req_addr_mask = s.amask; req_trap_lvl = s.tl;
        req_xlat_on = s.xen; req_implicit = s.impl; req_nofault_acc = s.nfa; req_ctx_type = s.ct;
        req_asi = s.asi; req_data_side = s.data; hit = s.hit; pg_priv = s.ppriv;
        pg_writable = s.pwr; pg_nofault = s.pnf; pg_side_effect = s.pse; pg_ppn = s.ppn;
        @(negedge clk);
        req_valid = 0;
        chk(ready == 1'b0, {"R2 busy ", name}, {63'b0, ready}, 64'd0);
        @(negedge clk);
        @(negedge clk);
        chk(!rsp_valid && ready, {"R2 retire ", name}, {62'b0, rsp_valid, ready}, 64'd1);
    endtask

    // Monitor: pops expected items as responses appear
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q.size() == 0) chk(0, "R2 unexpected response", 64'd1, 64'd0);
            else begin
                exp_t e;
                e = q.pop_front();
                chk(rsp_fault == e.kind, {"R3 kind ", e.name}, {61'b0, rsp_fault}, {61'b0, e.kind});
                if (e.kind == 0) begin
                    chk(rsp_pa == e.pa, {"R7 pa ", e.name}, {24'b0, rsp_pa}, {24'b0, e.pa});
                    chk(rsp_uncached == e.uc, {"R7 uc ", e.name}, {63'b0, rsp_uncached}, {63'b0, e.uc});
                end
                chk(fault_status == e.fsr, {"R8 fsr ", e.name}, fault_status, e.fsr);
                chk(fault_addr == e.far, {"R12 far ", e.name}, fault_addr, e.far);
                chk(tag_access == e.tag, {"R10 tag ", e.name}, tag_access, e.tag);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        stim_t s;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(fault_status == 0 && fault_addr == 0 && tag_access == 0, "R1 regs zero",
            fault_status | fault_addr | tag_access, 64'd0);
        chk(ready && !rsp_valid, "R1 idle", {62'b0, ready, rsp_valid}, 64'd2);

        s = base(); issue(s, "R7 plain hit");
        s = base(); s.pse = 1; issue(s, "R7 side-effect uncached");
        s = base(); s.ppn[26] = 1; issue(s, "R7 pa39 uncached");
        s = base(); s.va = 64'h0000_0000_0000_4002; s.szl = 2; issue(s, "R3 misalign data");
        s = base(); s.va = 64'h0000_0000_0000_5001; s.szl = 1; s.wr = 1; s.data = 0;
        issue(s, "R9 overwrite instr side");

        @(negedge clk); stat_clear = 1;
        @(negedge clk); stat_clear = 0; m_fsr = '0;
        chk(fault_status == 0, "R13 clear", fault_status, 64'd0);

        s = base(); s.va = 64'h0000_9000_0000_0000; issue(s, "R4 hole");
        s = base(); s.va = 64'h0000_9000_1234_6000; s.amask = 1; s.hit = 0; issue(s, "R4 masked miss");
        s = base(); s.xen = 0; s.hit = 0; issue(s, "R5 real miss");
        s = base(); s.priv = 0; s.ppriv = 1; s.pse = 1; issue(s, "R3 priv violation");
        s = base(); s.wr = 1; s.pwr = 0; issue(s, "R3 write protect");
        s = base(); s.pnf = 1; issue(s, "R3 nofault page");
        s = base(); s.pse = 1; s.nfa = 1; issue(s, "R3 side-effect nofault");
        s = base(); s.va = 64'h0000_0000_0000_0104; s.hit = 0; issue(s, "R3 misalign beats miss");
        s = base(); s.priv = 0; s.ppriv = 1; s.wr = 1; s.pwr = 0; issue(s, "R3 priv beats protect");
        s = base(); s.hpriv = 1; s.hit = 0; s.va = 64'hFFFF_FF80_ABCD_E000; issue(s, "R6 bypass");
        s = base(); s.hpriv = 1; s.va = 64'h0000_0000_0000_0003; s.szl = 1; issue(s, "R6 bypass misalign");
        s = base(); s.tl = 3'd2; s.priv = 0; s.ppriv = 1; issue(s, "R11 nucleus trap level");
        s = base(); s.impl = 0; s.ct = 2'd1; s.hit = 0; issue(s, "R11 secondary miss");
        s = base(); s.impl = 0; s.ct = 2'd1; s.wr = 1; s.pwr = 0; s.asi = 8'h81; issue(s, "R11 secondary protect");

        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R2 all responses seen", 64'(q.size()), 64'd0);
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule